// File: doc/BRIEF.md
# In-Order Graduation Active List

This block keeps every in-flight instruction in a circular list of entry slots. The rename stage appends up to four new entries per cycle at the tail, in program order. Each entry carries the physical register to release when that instruction retires. Execution units report completions by entry index, up to five per cycle and in any order. Each report can raise a fault flag for its entry.

Each cycle the block looks at the four oldest entries. It retires the longest run of them that are finished without a fault, starting from the oldest, and reports the released physical registers on four ordered lanes. A fault becomes a precise exception once the faulting entry is the oldest: it is reported with its index, nothing retires, and the list is emptied. A mispredicted branch cuts the list back to just behind the branch entry in a single cycle. A branch entry counts as unfinished until its resolution arrives as a completion report. Everything younger than the branch therefore waits behind it.

Top module: `grad_active_list`

## Requirements
- R1: The list holds at most 32 entries; `occupancy` never exceeds 32, and a list holding 32 entries accepts no new entry.
- R2: After reset the list is empty: `occupancy` is 0, `tail_idx` is 0, and `grad_valid`, `exc_valid` and `alloc_ok` are 0.
- R3: Up to four entries retire per cycle, oldest first. Lane 0 of `grad_valid` / `grad_preg` (bits 5:0 of `grad_preg`) is the oldest. The valid lanes always form a contiguous run from lane 0. A completion accepted at one clock edge makes the entry retire at the following edge, if all older entries have retired.
- R4: Retirement in a cycle stops at the first unfinished entry. Younger finished entries stay in the list until it finishes.
- R5: A fault stops retirement in front of the faulting entry. Older finished entries still retire. Once the faulting entry is oldest, `exc_valid` pulses for one cycle with `exc_idx` = its index, nothing retires in that cycle, `occupancy` becomes 0 and `tail_idx` becomes that index.
- R6: A branch entry whose resolution has not been reported blocks every younger entry from retiring, even entries that are finished.
- R7: A request of `alloc_n` = 1..4 entries is granted (`alloc_ok` = 1) when enough slots are free and no redirect or fault occurs in that cycle. The granted entries take indices `tail_idx`, `tail_idx`+1, … (mod 32), and lane j of `alloc_preg` (bits 6j+5:6j) goes to the j-th of them.
- R8: When fewer slots are free than requested, `alloc_ok` is 0 and neither `tail_idx` nor `occupancy` changes because of the request.
- R9: A redirect naming branch entry b sets `tail_idx` to b+1 and `occupancy` to the distance from the oldest entry through b, in one cycle. The dropped entries never retire, even if already finished. Any allocation requested in that cycle is refused.
- R10: Up to five completion reports are accepted in the same cycle, in any index order.
- R11: Entry indices wrap from 31 to 0 for both allocation and retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_n | input | 3 | Number of entries requested this cycle (0..4) |
| alloc_preg | input | 24 | Physical register to release, one 6-bit lane per requested entry |
| alloc_ok | output | 1 | Request granted this cycle |
| tail_idx | output | 5 | Index the next allocated entry receives |
| occupancy | output | 6 | Entries currently in the list |
| cmpl_valid | input | 5 | Completion report valid, one bit per report lane |
| cmpl_idx | input | 25 | Entry index per report lane, 5 bits each |
| cmpl_exc | input | 5 | Fault flag per report lane |
| redirect_valid | input | 1 | Mispredicted branch: truncate the list |
| redirect_idx | input | 5 | Index of the mispredicted branch entry |
| grad_valid | output | 4 | Retiring lanes this cycle, lane 0 oldest |
| grad_preg | output | 24 | Released physical register per retiring lane (0 on idle lanes) |
| exc_valid | output | 1 | Precise exception taken this cycle |
| exc_idx | output | 5 | Index of the faulting entry |

## Verification
The retire scan is tried with several completion patterns. Younger entries finishing before older ones show whether the scan stops at the first gap. Five reports in one cycle arriving in scrambled order show whether retirement follows age and not report order. An unresolved branch between finished entries, and a fault placed behind two finished entries, show whether the cut happens at the right lane. A redirect issued after the entries past the branch have already finished shows whether truncated work can leak out. A list filled to capacity across the index wrap separates an exact free-slot comparison from an off-by-one one, and checks that released registers come from the wrapped slots.

// File: rtl/grad_pkg.sv
package grad_pkg;
  // Default sizing of the active list.
  localparam int GL_DEPTH  = 32; // entries in flight
  localparam int GL_PREG_W = 6;  // physical register index width
  localparam int GL_ALLOC_W = 4; // entries appended per cycle
  localparam int GL_GRAD_W = 4;  // entries retired per cycle
  localparam int GL_CMPL_W = 5;  // completion reports per cycle
endpackage

// File: rtl/grad_entry_array.sv
// Per-entry state: finished/fault bits with reset, release register in a
// reset-free array. Exposes a window of the GRAD_W oldest entries.
module grad_entry_array #(
  parameter int DEPTH   = 32,
  parameter int PREG_W  = 6,
  parameter int ALLOC_W = 4,
  parameter int GRAD_W  = 4,
  parameter int CMPL_W  = 5,
  localparam int IDXW   = $clog2(DEPTH),
  localparam int ANW    = $clog2(ALLOC_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_we,
  input  logic [ANW-1:0]           alloc_n,
  input  logic [IDXW-1:0]          tail,
  input  logic [ALLOC_W*PREG_W-1:0] alloc_preg,
  input  logic [CMPL_W-1:0]        cmpl_valid,
  input  logic [CMPL_W*IDXW-1:0]   cmpl_idx,
  input  logic [CMPL_W-1:0]        cmpl_exc,
  input  logic [IDXW-1:0]          head,
  output logic [GRAD_W-1:0]        win_done,
  output logic [GRAD_W-1:0]        win_exc,
  output logic [GRAD_W*PREG_W-1:0] win_preg
);
  logic [DEPTH-1:0]  done_q;
  logic [DEPTH-1:0]  exc_q;
  logic [PREG_W-1:0] preg_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      for (int j = 0; j < ALLOC_W; j++) begin
        if (alloc_we && (ANW'(j) < alloc_n)) begin
          done_q[IDXW'(tail + IDXW'(j))] <= 1'b0;
          exc_q[IDXW'(tail + IDXW'(j))]  <= 1'b0;
        end
      end
      for (int c = 0; c < CMPL_W; c++) begin
        if (cmpl_valid[c]) begin
          done_q[cmpl_idx[c*IDXW +: IDXW]] <= 1'b1;
          if (cmpl_exc[c]) exc_q[cmpl_idx[c*IDXW +: IDXW]] <= 1'b1;
        end
      end
    end
  end

  // Release-register storage: write only, no reset.
  always_ff @(posedge clk) begin
    for (int j = 0; j < ALLOC_W; j++) begin
      if (alloc_we && (ANW'(j) < alloc_n))
        preg_mem[IDXW'(tail + IDXW'(j))] <= alloc_preg[j*PREG_W +: PREG_W];
    end
  end

  for (genvar g = 0; g < GRAD_W; g++) begin : g_win
    logic [IDXW-1:0] rd_idx;
    assign rd_idx = IDXW'(head + IDXW'(g));
    assign win_done[g] = done_q[rd_idx];
    assign win_exc[g]  = exc_q[rd_idx];
    assign win_preg[g*PREG_W +: PREG_W] = preg_mem[rd_idx];
  end
endmodule

// File: rtl/grad_select.sv
// Picks the retiring run from the oldest-entry window and detects a
// fault sitting at the oldest slot.
module grad_select #(
  parameter int GRAD_W = 4,
  parameter int CNTW   = 6,
  localparam int GKW   = $clog2(GRAD_W + 1)
) (
  input  logic [GRAD_W-1:0] win_done,
  input  logic [GRAD_W-1:0] win_exc,
  input  logic [CNTW-1:0]   avail,
  output logic [GRAD_W-1:0] grad_mask,
  output logic [GKW-1:0]    grad_k,
  output logic              fault_head
);
  always_comb begin
    logic run;
    run       = 1'b1;
    grad_mask = '0;
    grad_k    = '0;
    for (int g = 0; g < GRAD_W; g++) begin
      if (run && (CNTW'(g) < avail) && win_done[g] && !win_exc[g]) begin
        grad_mask[g] = 1'b1;
        grad_k       = grad_k + 1'b1;
      end else begin
        run = 1'b0;
      end
    end
    fault_head = (avail != '0) && win_done[0] && win_exc[0];
  end
endmodule

// File: rtl/grad_active_list.sv
module grad_active_list
  import grad_pkg::*;
#(
  parameter int DEPTH   = GL_DEPTH,
  parameter int PREG_W  = GL_PREG_W,
  parameter int ALLOC_W = GL_ALLOC_W,
  parameter int GRAD_W  = GL_GRAD_W,
  parameter int CMPL_W  = GL_CMPL_W,
  localparam int IDXW   = $clog2(DEPTH),
  localparam int CNTW   = IDXW + 1,
  localparam int ANW    = $clog2(ALLOC_W + 1),
  localparam int GKW    = $clog2(GRAD_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ANW-1:0]            alloc_n,
  input  logic [ALLOC_W*PREG_W-1:0] alloc_preg,
  output logic                      alloc_ok,
  output logic [IDXW-1:0]           tail_idx,
  output logic [CNTW-1:0]           occupancy,
  input  logic [CMPL_W-1:0]         cmpl_valid,
  input  logic [CMPL_W*IDXW-1:0]    cmpl_idx,
  input  logic [CMPL_W-1:0]         cmpl_exc,
  input  logic                      redirect_valid,
  input  logic [IDXW-1:0]           redirect_idx,
  output logic [GRAD_W-1:0]         grad_valid,
  output logic [GRAD_W*PREG_W-1:0]  grad_preg,
  output logic                      exc_valid,
  output logic [IDXW-1:0]           exc_idx
);
  logic [IDXW-1:0]          head_q, tail_q;
  logic [CNTW-1:0]          cnt_q;
  logic [GRAD_W-1:0]        win_done, win_exc, grad_mask;
  logic [GRAD_W*PREG_W-1:0] win_preg;
  logic [GKW-1:0]           grad_k;
  logic                     fault;
  logic [CNTW-1:0]          space, cut_cnt, avail;
  logic [IDXW-1:0]          cut_dist;

  // Entries kept by a redirect: oldest entry through the branch.
  assign cut_dist = redirect_idx - head_q;
  assign cut_cnt  = CNTW'(cut_dist) + CNTW'(1);
  assign avail    = redirect_valid ? cut_cnt : cnt_q;
  assign space    = CNTW'(DEPTH) - cnt_q;
  assign alloc_ok = (alloc_n != '0) && (CNTW'(alloc_n) <= space) &&
                    !redirect_valid && !fault;

  grad_entry_array #(
    .DEPTH(DEPTH), .PREG_W(PREG_W), .ALLOC_W(ALLOC_W),
    .GRAD_W(GRAD_W), .CMPL_W(CMPL_W)
  ) u_entries (
    .clk(clk), .rst(rst),
    .alloc_we(alloc_ok), .alloc_n(alloc_n), .tail(tail_q),
    .alloc_preg(alloc_preg),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_exc(cmpl_exc),
    .head(head_q),
    .win_done(win_done), .win_exc(win_exc), .win_preg(win_preg)
  );

  grad_select #(.GRAD_W(GRAD_W), .CNTW(CNTW)) u_select (
    .win_done(win_done), .win_exc(win_exc), .avail(avail),
    .grad_mask(grad_mask), .grad_k(grad_k), .fault_head(fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (fault) begin
      // Precise exception: drop the faulting entry and all younger ones.
      tail_q <= head_q;
      cnt_q  <= '0;
    end else begin
      head_q <= head_q + IDXW'(grad_k);
      if (redirect_valid)
        tail_q <= redirect_idx + IDXW'(1);
      else if (alloc_ok)
        tail_q <= tail_q + IDXW'(alloc_n);
      cnt_q <= avail - CNTW'(grad_k) + (alloc_ok ? CNTW'(alloc_n) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grad_valid <= '0;
      grad_preg  <= '0;
      exc_valid  <= 1'b0;
      exc_idx    <= '0;
    end else begin
      grad_valid <= grad_mask;
      for (int g = 0; g < GRAD_W; g++)
        grad_preg[g*PREG_W +: PREG_W] <=
          grad_mask[g] ? win_preg[g*PREG_W +: PREG_W] : '0;
      exc_valid <= fault;
      exc_idx   <= head_q;
    end
  end

  assign tail_idx  = tail_q;
  assign occupancy = cnt_q;
endmodule

// File: rtl/grad_active_list_chk.sv
module grad_active_list_chk #(
  parameter int DEPTH   = 32,
  parameter int ALLOC_W = 4,
  parameter int GRAD_W  = 4,
  localparam int IDXW   = $clog2(DEPTH),
  localparam int CNTW   = IDXW + 1,
  localparam int ANW    = $clog2(ALLOC_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ANW-1:0]    alloc_n,
  input logic              alloc_ok,
  input logic [IDXW-1:0]   tail_idx,
  input logic [CNTW-1:0]   occupancy,
  input logic              redirect_valid,
  input logic [IDXW-1:0]   redirect_idx,
  input logic [GRAD_W-1:0] grad_valid,
  input logic              exc_valid
);
  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(occupancy) <= DEPTH); // R1

  AST_GRAD_CONTIG: assert property (@(posedge clk) disable iff (rst)
    (GRAD_W'(grad_valid + 1'b1) & grad_valid) == '0); // R3

  AST_FAULT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (grad_valid == '0) && (occupancy == '0)); // R5

  AST_GRANT_FITS: assert property (@(posedge clk) disable iff (rst)
    alloc_ok |-> (int'(alloc_n) + int'(occupancy) <= DEPTH)); // R8

  AST_ALLOC_TAIL: assert property (@(posedge clk) disable iff (rst)
    alloc_ok |=> tail_idx == IDXW'($past(tail_idx) + IDXW'($past(alloc_n)))); // R7

  AST_REDIRECT_TAIL: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> exc_valid || (tail_idx == IDXW'($past(redirect_idx) + 1'b1))); // R9
endmodule

bind grad_active_list grad_active_list_chk #(
  .DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .GRAD_W(GRAD_W)
) u_chk (.*);

// File: tb/grad_active_list_tb.sv
`timescale 1ns/1ps
module grad_active_list_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  alloc_n = '0;
  logic [23:0] alloc_preg = '0;
  logic        alloc_ok;
  logic [4:0]  tail_idx;
  logic [5:0]  occupancy;
  logic [4:0]  cmpl_valid = '0;
  logic [24:0] cmpl_idx = '0;
  logic [4:0]  cmpl_exc = '0;
  logic        redirect_valid = 1'b0;
  logic [4:0]  redirect_idx = '0;
  logic [3:0]  grad_valid;
  logic [23:0] grad_preg;
  logic        exc_valid;
  logic [4:0]  exc_idx;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  grad_active_list u_dut (
    .clk(clk), .rst(rst), .alloc_n(alloc_n), .alloc_preg(alloc_preg),
    .alloc_ok(alloc_ok), .tail_idx(tail_idx), .occupancy(occupancy),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_exc(cmpl_exc),
    .redirect_valid(redirect_valid), .redirect_idx(redirect_idx),
    .grad_valid(grad_valid), .grad_preg(grad_preg),
    .exc_valid(exc_valid), .exc_idx(exc_idx)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_grad(string tag, int mask, int p0, int p1, int p2, int p3);
    int exp_p[4];
    exp_p = '{p0, p1, p2, p3};
    check({tag, " grad_valid"}, int'(grad_valid), mask);
    for (int g = 0; g < 4; g++)
      if (mask[g]) check({tag, " grad_preg lane"}, int'(grad_preg[g*6 +: 6]), exp_p[g]);
  endtask

  task automatic do_alloc(string tag, int n, int base, int exp_ok);
    alloc_n = 3'(n);
    for (int j = 0; j < 4; j++) alloc_preg[j*6 +: 6] = 6'(base + j);
    #1;
    check({tag, " alloc_ok"}, int'(alloc_ok), exp_ok);
    step();
    alloc_n = '0;
  endtask

  task automatic cmpl_set(int lane, int idx, bit ex);
    cmpl_valid[lane] = 1'b1;
    cmpl_idx[lane*5 +: 5] = 5'(idx);
    cmpl_exc[lane] = ex;
  endtask

  task automatic cmpl_fire();
    step();
    cmpl_valid = '0;
    cmpl_exc = '0;
  endtask

  task automatic t_reset();
    step();
    check("R2 occupancy", int'(occupancy), 0);
    check("R2 tail", int'(tail_idx), 0);
    check("R2 grad_valid", int'(grad_valid), 0);
    check("R2 exc_valid", int'(exc_valid), 0);
    check("R2 alloc_ok", int'(alloc_ok), 0);
  endtask

  task automatic t_in_order();
    do_alloc("R7 four", 4, 10, 1);
    check("R7 tail", int'(tail_idx), 4);
    check("R7 occupancy", int'(occupancy), 4);
    cmpl_set(0, 3, 0); cmpl_set(1, 2, 0);
    cmpl_fire();
    check_grad("R4 younger done", 0, 0, 0, 0, 0);
    step();
    check_grad("R4 younger wait", 0, 0, 0, 0, 0);
    cmpl_set(0, 0, 0);
    cmpl_fire();
    step();
    check_grad("R4 stop at gap", 1, 10, 0, 0, 0);
    check("R4 occupancy", int'(occupancy), 3);
    cmpl_set(0, 1, 0);
    cmpl_fire();
    step();
    check_grad("R3 run of three", 7, 11, 12, 13, 0);
    check("R3 occupancy", int'(occupancy), 0);
  endtask

  task automatic t_five_reports();
    do_alloc("R10 alloc a", 4, 50, 1);
    do_alloc("R10 alloc b", 1, 54, 1);
    check("R10 tail", int'(tail_idx), 9);
    cmpl_set(0, 8, 0); cmpl_set(1, 6, 0); cmpl_set(2, 4, 0);
    cmpl_set(3, 7, 0); cmpl_set(4, 5, 0);
    cmpl_fire();
    step();
    check_grad("R10 first four", 15, 50, 51, 52, 53);
    step();
    check_grad("R3 fifth next cycle", 1, 54, 0, 0, 0);
    check("R10 occupancy", int'(occupancy), 0);
  endtask

  task automatic t_branch();
    do_alloc("R6 alloc", 3, 20, 1);
    cmpl_set(0, 9, 0); cmpl_set(1, 11, 0);
    cmpl_fire();
    step();
    check_grad("R6 older retires", 1, 20, 0, 0, 0);
    step();
    check_grad("R6 blocked by branch", 0, 0, 0, 0, 0);
    cmpl_set(0, 10, 0);
    cmpl_fire();
    step();
    check_grad("R6 resolved", 3, 21, 22, 0, 0);
    check("R6 tail", int'(tail_idx), 12);
  endtask

  task automatic t_redirect();
    do_alloc("R9 alloc a", 4, 30, 1);
    do_alloc("R9 alloc b", 2, 34, 1);
    cmpl_set(0, 14, 0); cmpl_set(1, 15, 0); cmpl_set(2, 16, 0); cmpl_set(3, 17, 0);
    cmpl_fire();
    redirect_valid = 1'b1;
    redirect_idx = 5'd13;
    alloc_n = 3'd2;
    #1;
    check("R9 alloc refused", int'(alloc_ok), 0);
    step();
    redirect_valid = 1'b0;
    alloc_n = '0;
    check("R9 tail", int'(tail_idx), 14);
    check("R9 occupancy", int'(occupancy), 2);
    cmpl_set(0, 12, 0); cmpl_set(1, 13, 0);
    cmpl_fire();
    step();
    check_grad("R9 kept entries", 3, 30, 31, 0, 0);
    step();
    check_grad("R9 dropped stay out", 0, 0, 0, 0, 0);
    check("R9 empty", int'(occupancy), 0);
  endtask

  task automatic t_fault();
    do_alloc("R5 alloc", 3, 40, 1);
    cmpl_set(0, 14, 0); cmpl_set(1, 15, 0); cmpl_set(2, 16, 1);
    cmpl_fire();
    step();
    check_grad("R5 older retire", 3, 40, 41, 0, 0);
    check("R5 no early exc", int'(exc_valid), 0);
    step();
    check("R5 exc_valid", int'(exc_valid), 1);
    check("R5 exc_idx", int'(exc_idx), 16);
    check_grad("R5 nothing retires", 0, 0, 0, 0, 0);
    check("R5 occupancy", int'(occupancy), 0);
    check("R5 tail", int'(tail_idx), 16);
    step();
    check("R5 one pulse", int'(exc_valid), 0);
  endtask

  task automatic t_full_wrap();
    for (int k = 0; k < 8; k++) do_alloc("R1 fill", 4, k * 4, 1);
    check("R1 occupancy full", int'(occupancy), 32);
    check("R11 tail wrapped", int'(tail_idx), 16);
    do_alloc("R1 full refuses", 1, 60, 0);
    check("R8 occupancy kept", int'(occupancy), 32);
    check("R8 tail kept", int'(tail_idx), 16);
    cmpl_set(0, 16, 0);
    cmpl_fire();
    step();
    check_grad("R11 retire after wrap", 1, 0, 0, 0, 0);
    check("R8 one free", int'(occupancy), 31);
    do_alloc("R8 two into one", 2, 60, 0);
    check("R8 occupancy after refuse", int'(occupancy), 31);
    do_alloc("R8 exact fit", 1, 61, 1);
    check("R1 full again", int'(occupancy), 32);
    check("R11 tail", int'(tail_idx), 17);
    cmpl_set(0, 17, 1);
    cmpl_fire();
    step();
    check("R5 fault on full list", int'(exc_valid), 1);
    check("R5 fault index", int'(exc_idx), 17);
    check("R5 drained", int'(occupancy), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: cycles actual %0d expected below %0d", cycles, 20000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_in_order();
    t_five_reports();
    t_branch();
    t_redirect();
    t_fault();
    t_full_wrap();
    step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule